// File: doc/BRIEF.md
# Multiplexed-Address Burst Command Sequencer

This block sits on the controller side of a narrow memory channel. It takes one request at a time, a read or a write with a 16-bit row and a 16-bit column, and turns it into a fixed sequence on a shared 8-bit address bus and two pairs of command pins. The row is sent as two 8-bit halves on consecutive cycles with the select and row-strobe pins high. A fixed row-to-column delay later, the column is sent the same way with the column-strobe pin high. The write-enable pin is also high during the column phase of a write.

A fixed column-to-data delay after the first column cycle, an 8-beat burst moves on the 18-bit data bus. For a write, the block asks for one data word per beat one cycle ahead and drives it onto the bus. For a read, it captures the bus on each beat and presents the word one cycle later with a valid flag. A reference strobe flips at the start of every beat, so its level gives the beat parity. Requests use a ready/valid handshake. A new request is taken in the last column cycle of the one before, which gives a 12-cycle request period at the default delays.

Top module: `mxcmd_seq`

## Requirements
- R1: After synchronous reset, req_ready is high and pin_sel, pin_rstb, pin_cstb, pin_wen, dq_oe, wr_data_req, rd_valid and ref_strb are all low.
- R2: Number the cycles after the clock edge that accepts a request (req_valid and req_ready both high) as 1, 2, and so on. In cycles 1 and 2, pin_sel and pin_rstb are high and addr_bus carries row bits 7:0 and then row bits 15:8. Outside row and column cycles, addr_bus is 0 and all four command pins are low.
- R3: In cycles 11 and 12, pin_cstb is high and addr_bus carries column bits 7:0 and then column bits 15:8. pin_wen is high in those two cycles only for a write (req_write = 1).
- R4: req_ready is low in cycles 1 to 11 and high from cycle 12. A req_valid raised while req_ready is low issues no command.
- R5: For a write, wr_data_req is high in cycles 20 to 27. dq_oe is high in cycles 21 to 28, and in cycle 21+k dq_out equals the wr_data value present in cycle 20+k.
- R6: For a read, dq_in is captured in cycles 21 to 28. rd_valid is high in cycles 22 to 29, and in cycle 22+k rd_data equals the dq_in value of cycle 21+k. A read never raises dq_oe or wr_data_req.
- R7: ref_strb inverts at the start of each of cycles 21 to 28 and holds its level in every other cycle, so it flips exactly 8 times per burst.
- R8: With req_valid held high, requests are accepted every 12 cycles. A read, read, write, read series then gives 24 rd_valid cycles, 8 wr_data_req cycles, 2 pin_wen cycles and 8 pin_sel cycles, and dq_oe and rd_valid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | 16 | Row address |
| req_col | input | 16 | Column address |
| pin_sel | output | 1 | Chip select, paired with row strobe |
| pin_rstb | output | 1 | Row strobe |
| pin_cstb | output | 1 | Column strobe, paired with write enable |
| pin_wen | output | 1 | Write enable |
| addr_bus | output | 8 | Multiplexed address halves |
| dq_out | output | 18 | Write data to the bus |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 18 | Read data from the bus |
| ref_strb | output | 1 | Per-beat toggling reference strobe |
| wr_data_req | output | 1 | Asks for the next write word |
| wr_data | input | 18 | Write word, taken while wr_data_req is high |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 18 | Read word |

## Verification
The hardest case to reach is the overlap of two requests. A new command's row and column phases run on the address bus while the previous burst is still moving data and flipping the reference strobe. A second request can only be taken in the single cycle when the previous column phase ends, so the overlap appears only if req_valid is held high through that cycle with the next request's fields already in place. The back-to-back scenario does this by keeping req_valid high and updating the fields right after each accepted edge. A separate scenario raises req_valid in the middle of a busy phase to confirm that no command is issued.

// File: rtl/mxcmd_pkg.sv
package mxcmd_pkg;
    localparam int ROW_W   = 16;
    localparam int ADDR_W  = 8;
    localparam int DQ_W    = 18;
    localparam int BURST   = 8;
    localparam int R2C_DLY = 10;
    localparam int C2D_DLY = 10;

    typedef struct packed {
        logic             write;
        logic [ROW_W-1:0] row;
        logic [ROW_W-1:0] col;
    } req_t;

    typedef struct packed {
        logic valid;
        logic write;
    } launch_t;

    function automatic logic [ADDR_W-1:0] half_sel(input logic [ROW_W-1:0] a, input logic upper);
        return upper ? a[ROW_W-1:ADDR_W] : a[ADDR_W-1:0];
    endfunction
endpackage

// File: rtl/mxcmd_addr_seq.sv
module mxcmd_addr_seq
    import mxcmd_pkg::*;
#(
    parameter int R2C = R2C_DLY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  req_t              req_in,
    output logic              pin_sel,
    output logic              pin_rstb,
    output logic              pin_cstb,
    output logic              pin_wen,
    output logic [ADDR_W-1:0] addr_bus,
    output launch_t           launch
);
    localparam int LAST  = R2C + 2;
    localparam int CNT_W = $clog2(LAST + 1);

    logic [CNT_W-1:0] cnt;
    req_t             held;
    logic             accept;
    logic             row_lo, row_hi, col_lo, col_hi;

    assign req_ready = (cnt == '0) || (cnt == CNT_W'(LAST));
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            held <= '0;
        end else begin
            if (accept) begin
                cnt  <= CNT_W'(1);
                held <= req_in;
            end else if (cnt == CNT_W'(LAST)) begin
                cnt <= '0;
            end else if (cnt != '0) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign row_lo = (cnt == CNT_W'(1));
    assign row_hi = (cnt == CNT_W'(2));
    assign col_lo = (cnt == CNT_W'(R2C + 1));
    assign col_hi = (cnt == CNT_W'(R2C + 2));

    always_comb begin
        pin_sel  = row_lo || row_hi;
        pin_rstb = row_lo || row_hi;
        pin_cstb = col_lo || col_hi;
        pin_wen  = (col_lo || col_hi) && held.write;
        if (pin_sel)
            addr_bus = half_sel(held.row, row_hi);
        else if (pin_cstb)
            addr_bus = half_sel(held.col, col_hi);
        else
            addr_bus = '0;
        launch.valid = col_lo;
        launch.write = held.write;
    end
endmodule

// File: rtl/mxcmd_delay_line.sv
module mxcmd_delay_line
    import mxcmd_pkg::*;
#(
    parameter int DEPTH = C2D_DLY - 1
) (
    input  logic    clk,
    input  logic    rst,
    input  launch_t din,
    output launch_t dout
);
    launch_t stage [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage[g] <= '0;
                else if (g == 0)
                    stage[g] <= din;
                else
                    stage[g] <= stage[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/mxcmd_beat_eng.sv
module mxcmd_beat_eng
    import mxcmd_pkg::*;
#(
    parameter int BLEN = BURST
) (
    input  logic            clk,
    input  logic            rst,
    input  launch_t         start,
    input  logic [DQ_W-1:0] wr_data,
    input  logic [DQ_W-1:0] dq_in,
    output logic            wr_data_req,
    output logic [DQ_W-1:0] dq_out,
    output logic            dq_oe,
    output logic            ref_strb,
    output logic            rd_valid,
    output logic [DQ_W-1:0] rd_data
);
    localparam int IDX_W = (BLEN > 1) ? $clog2(BLEN) : 1;

    logic             active;
    logic             is_wr;
    logic [IDX_W-1:0] idx;
    logic             next_beat;

    assign next_beat   = start.valid || (active && (idx != IDX_W'(BLEN-1)));
    assign wr_data_req = next_beat && (start.valid ? start.write : is_wr);
    assign dq_oe       = active && is_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            is_wr    <= 1'b0;
            idx      <= '0;
            ref_strb <= 1'b0;
            dq_out   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (start.valid) begin
                active <= 1'b1;
                idx    <= '0;
                is_wr  <= start.write;
            end else if (active) begin
                if (idx == IDX_W'(BLEN-1))
                    active <= 1'b0;
                else
                    idx <= idx + IDX_W'(1);
            end
            ref_strb <= ref_strb ^ next_beat;
            if (wr_data_req)
                dq_out <= wr_data;
            rd_valid <= active && !is_wr;
            if (active && !is_wr)
                rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/mxcmd_seq.sv
module mxcmd_seq
    import mxcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [ROW_W-1:0]  req_col,
    output logic              pin_sel,
    output logic              pin_rstb,
    output logic              pin_cstb,
    output logic              pin_wen,
    output logic [ADDR_W-1:0] addr_bus,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    input  logic [DQ_W-1:0]   dq_in,
    output logic              ref_strb,
    output logic              wr_data_req,
    input  logic [DQ_W-1:0]   wr_data,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data
);
    localparam int LINE_DEPTH = C2D_DLY - 1;

    req_t    req_in;
    launch_t launch;
    launch_t start;

    assign req_in = '{write: req_write, row: req_row, col: req_col};

    mxcmd_addr_seq #(.R2C(R2C_DLY)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_in    (req_in),
        .pin_sel   (pin_sel),
        .pin_rstb  (pin_rstb),
        .pin_cstb  (pin_cstb),
        .pin_wen   (pin_wen),
        .addr_bus  (addr_bus),
        .launch    (launch)
    );

    mxcmd_delay_line #(.DEPTH(LINE_DEPTH)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (launch),
        .dout (start)
    );

    mxcmd_beat_eng #(.BLEN(BURST)) u_beat (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .wr_data     (wr_data),
        .dq_in       (dq_in),
        .wr_data_req (wr_data_req),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe),
        .ref_strb    (ref_strb),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );
endmodule

// File: rtl/mxcmd_seq_chk.sv
module mxcmd_seq_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic pin_sel,
    input logic pin_rstb,
    input logic pin_cstb,
    input logic pin_wen,
    input logic dq_oe,
    input logic wr_data_req,
    input logic rd_valid,
    input logic ref_strb
);
    // R2: a row phase begins only one cycle after an accepted request
    assert_row_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pin_sel) |-> $past(req_valid && req_ready));

    // R3: write enable appears only inside the column phase
    assert_wen_in_col_R3: assert property (@(posedge clk) disable iff (rst)
        pin_wen |-> pin_cstb);

    // R4: after an accept, no second request is taken on the next cycle
    assert_holdoff_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R5: the data bus is driven only one cycle after a write word was requested
    assert_oe_follows_req_R5: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> $past(wr_data_req));

    // R6: read results never coincide with the write drive
    assert_rd_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !dq_oe);

    // R7: consecutive write beats each flip the strobe
    assert_ref_flip_R7: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> !$stable(ref_strb));

    // R8: the row and column phases never share a cycle
    assert_phase_excl_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pin_rstb, pin_cstb}));
endmodule

bind mxcmd_seq mxcmd_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .pin_sel     (pin_sel),
    .pin_rstb    (pin_rstb),
    .pin_cstb    (pin_cstb),
    .pin_wen     (pin_wen),
    .dq_oe       (dq_oe),
    .wr_data_req (wr_data_req),
    .rd_valid    (rd_valid),
    .ref_strb    (ref_strb)
);

// File: tb/mxcmd_seq_tb_top.sv
module mxcmd_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_row = '0;
    logic [15:0] req_col = '0;
    logic        pin_sel, pin_rstb, pin_cstb, pin_wen;
    logic [7:0]  addr_bus;
    logic [17:0] dq_out;
    logic        dq_oe;
    logic [17:0] dq_in = '0;
    logic        ref_strb;
    logic        wr_data_req;
    logic [17:0] wr_data = '0;
    logic        rd_valid;
    logic [17:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mxcmd_seq dut_i (.*);

    function automatic logic [17:0] wpat(input int k);
        return 18'(32'h2A5F1 ^ (k * 32'h1357));
    endfunction

    function automatic logic [17:0] rpat(input int k);
        return 18'(32'h15A0E + (k * 32'h0F0D3));
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // R1: state during and after reset
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready", 32'(req_ready), 1);
        chk({pin_sel, pin_rstb, pin_cstb, pin_wen} == 4'b0, "R1", "cmd pins",
            32'({pin_sel, pin_rstb, pin_cstb, pin_wen}), 0);
        chk({dq_oe, wr_data_req, rd_valid} == 3'b0, "R1", "data ctrl",
            32'({dq_oe, wr_data_req, rd_valid}), 0);
        chk(ref_strb == 1'b0, "R1", "ref_strb", 32'(ref_strb), 0);
    endtask

    // R2 R3 R4 R5 R6 R7: one isolated command, checked cycle by cycle
    task automatic t_single(input logic wr, input logic [15:0] row, input logic [15:0] col);
        logic base;
        logic [7:0] ea;
        int tog;
        req_write = wr; req_row = row; req_col = col; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        base = ref_strb ^ 1'b0;
        for (int c = 1; c <= 31; c++) begin
            ea = (c == 1) ? row[7:0] : (c == 2) ? row[15:8] :
                 (c == 11) ? col[7:0] : (c == 12) ? col[15:8] : 8'h00;
            chk(pin_sel == (c <= 2) && pin_rstb == (c <= 2), "R2", $sformatf("row strobes c%0d", c),
                32'({pin_sel, pin_rstb}), (c <= 2) ? 3 : 0);
            chk(addr_bus == ea, (c <= 2) ? "R2" : "R3", $sformatf("addr c%0d", c), 32'(addr_bus), 32'(ea));
            chk(pin_cstb == (c == 11 || c == 12), "R3", $sformatf("cstb c%0d", c),
                32'(pin_cstb), 32'(c == 11 || c == 12));
            chk(pin_wen == (wr && (c == 11 || c == 12)), "R3", $sformatf("wen c%0d", c),
                32'(pin_wen), 32'(wr && (c == 11 || c == 12)));
            chk(req_ready == (c >= 12), "R4", $sformatf("ready c%0d", c), 32'(req_ready), 32'(c >= 12));
            chk(wr_data_req == (wr && c >= 20 && c <= 27), "R5", $sformatf("wreq c%0d", c),
                32'(wr_data_req), 32'(wr && c >= 20 && c <= 27));
            chk(dq_oe == (wr && c >= 21 && c <= 28), "R5", $sformatf("oe c%0d", c),
                32'(dq_oe), 32'(wr && c >= 21 && c <= 28));
            if (wr && c >= 21 && c <= 28)
                chk(dq_out == wpat(c - 21), "R5", $sformatf("dq_out c%0d", c), 32'(dq_out), 32'(wpat(c - 21)));
            chk(rd_valid == (!wr && c >= 22 && c <= 29), "R6", $sformatf("rd_valid c%0d", c),
                32'(rd_valid), 32'(!wr && c >= 22 && c <= 29));
            if (!wr && c >= 22 && c <= 29)
                chk(rd_data == rpat(c - 22), "R6", $sformatf("rd_data c%0d", c), 32'(rd_data), 32'(rpat(c - 22)));
            tog = (c <= 20) ? 0 : (c >= 28) ? 8 : c - 20;
            chk(ref_strb == (base ^ tog[0]), "R7", $sformatf("ref c%0d", c), 32'(ref_strb), 32'(base ^ tog[0]));
            wr_data = wpat(c - 20);
            dq_in   = rpat(c - 21);
            @(negedge clk);
        end
    endtask

    // R4: a request raised while busy is not issued
    task automatic t_holdoff();
        int sel_cyc = 0;
        req_write = 1'b0; req_row = 16'h1234; req_col = 16'h0042; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 1; c <= 40; c++) begin
            if (c == 3) begin req_valid = 1'b1; req_row = 16'hBEEF; end
            if (c == 7) req_valid = 1'b0;
            if (pin_sel) sel_cyc++;
            if (pin_sel && addr_bus == 8'hEF)
                chk(1'b0, "R4", "busy request issued", 32'(addr_bus), 32'h34);
            @(negedge clk);
        end
        chk(sel_cyc == 2, "R4", "row cycles after busy request", 32'(sel_cyc), 2);
    endtask

    // R8: read, read, write, read with valid held high
    task automatic t_b2b();
        int acc [4];
        int i = 0;
        int cyc = 0;
        int n_rd = 0, n_wr = 0, n_wen = 0, n_sel = 0;
        logic rdy;
        req_write = 1'b0; req_row = 16'h0100; req_col = 16'h0200; req_valid = 1'b1;
        while (cyc < 120) begin
            rdy = req_ready && req_valid;
            @(negedge clk);
            cyc++;
            if (rdy && i < 4) begin
                acc[i] = cyc;
                i++;
                if (i < 4) begin
                    req_write = (i == 2);
                    req_row = 16'(16'h0100 + i);
                    req_col = 16'(16'h0200 + i);
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (rd_valid) n_rd++;
            if (wr_data_req) n_wr++;
            if (pin_wen) n_wen++;
            if (pin_sel) n_sel++;
            if (rd_valid && dq_oe) chk(1'b0, "R8", "read and drive together", 1, 0);
        end
        chk(i == 4, "R8", "accepted count", 32'(i), 4);
        for (int k = 1; k < 4; k++)
            chk(acc[k] - acc[k-1] == 12, "R8", $sformatf("spacing %0d", k), 32'(acc[k] - acc[k-1]), 12);
        chk(n_rd == 24, "R8", "rd_valid cycles", 32'(n_rd), 24);
        chk(n_wr == 8, "R8", "wr_data_req cycles", 32'(n_wr), 8);
        chk(n_wen == 2, "R8", "wen cycles", 32'(n_wen), 2);
        chk(n_sel == 8, "R8", "sel cycles", 32'(n_sel), 8);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_single(1'b0, 16'hA5C3, 16'h3C96);
        t_single(1'b1, 16'h0F1E, 16'hE1F0);
        t_single(1'b0, 16'hFFFF, 16'h0000);
        t_holdoff();
        repeat (30) @(negedge clk);
        t_b2b();
        t_reset();
        finish_run();
    end
endmodule